// File: doc/BRIEF.md
# Synchronous Memory Sleep Controller

This block sits between a host's command pins and a synchronous memory core and manages a low-power sleep state. The sleep request is asynchronous: it passes through a two-stage synchroniser, and only a request that stays high on two consecutive synchronised cycles puts the memory to sleep. While the memory is asleep, every command is stopped before it reaches the core and the data output enable is held off. The core keeps its contents because it never sees a command.

When the request drops, the controller does not return to normal operation at once. It opens a recovery window whose length is a whole number of clock cycles, derived from a time budget and the clock period. Inside that window, deselect and read commands pass through and write commands are blocked. A blocked write sets an error flag that holds until reset. A new request during the window puts the memory back to sleep with the usual delay.

Top module: `sram_sleep_ctrl`

## Requirements
- R1: After reset, `sleep_o`, `recov_o` and `err_o` are 0 and `gate_o` is 1.
- R2: With `sleep_req_i` held high, `sleep_o` becomes 1 after the fourth rising edge that samples it high: two synchroniser stages, then two cycles of entry delay.
- R3: A request that is sampled high on only one edge and then returns low never asserts `sleep_o`.
- R4: While `sleep_o` is 1, `gate_o`, `core_sel_o`, `core_wr_o` and `out_en_o` are all 0, whatever `sel_i`, `wr_i` and `oe_i` do.
- R5: After the first edge that samples `sleep_req_i` low during sleep, `sleep_o` falls and `recov_o` rises after the third edge. `recov_o` then stays high for exactly REC_CYC cycles, where REC_CYC = ceil(RECOVERY_PS / CLK_PERIOD_PS) with a minimum of 1.
- R6: During recovery, a deselect (`sel_i`=0) or a read (`sel_i`=1, `wr_i`=0) passes through. `gate_o` is 1, `core_sel_o` follows `sel_i` and `core_wr_o` is 0.
- R7: During recovery, a write (`sel_i`=1, `wr_i`=1) is blocked. `gate_o`, `core_sel_o` and `core_wr_o` are 0.
- R8: `err_o` rises on the edge that ends a blocked write and stays 1 until reset, with no further writes needed.
- R9: When neither asleep nor recovering, `gate_o` is 1, `core_sel_o` = `sel_i`, `core_wr_o` = `sel_i & wr_i` and `out_en_o` = `oe_i`. A write here leaves `err_o` unchanged.
- R10: A request raised during recovery returns `sleep_o` to 1 with the same four-edge latency as in R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| sleep_req_i | input | 1 | Asynchronous sleep request, active high |
| sel_i | input | 1 | Host command select (0 = deselect) |
| wr_i | input | 1 | Host write qualifier (1 = write when selected) |
| oe_i | input | 1 | Host data output enable request |
| core_sel_o | output | 1 | Select forwarded to the memory core |
| core_wr_o | output | 1 | Write forwarded to the memory core |
| out_en_o | output | 1 | Data output driver enable |
| gate_o | output | 1 | 1 when the current command is let through |
| sleep_o | output | 1 | 1 while asleep |
| recov_o | output | 1 | 1 during the recovery window |
| err_o | output | 1 | Sticky flag: write attempted during recovery |

## Verification
A wrong state or counter value appears at the ports in the same cycle. `sleep_o` and `recov_o` decode the state directly, and the gating outputs depend on it through combinational logic only. An entry counter that is off by one moves the `sleep_o` edge by one cycle, and an error in the recovery counter changes how many cycles `recov_o` stays high. Both are measured edge by edge against a cycle model in the bench, along with every gated output on every cycle. A missed or spurious error shows up on `err_o` one edge after the write in question and then stays, so it cannot go unnoticed.

// File: rtl/sram_sleep_pkg.sv
`timescale 1ns/1ps
package sram_sleep_pkg;

  typedef enum logic [1:0] {
    ST_AWAKE   = 2'd0,
    ST_ASLEEP  = 2'd1,
    ST_RECOVER = 2'd2
  } slp_state_e;

  // Whole clock cycles that cover a time window, never fewer than one.
  function automatic int unsigned cycles_for(input int unsigned win_ps,
                                             input int unsigned per_ps);
    int unsigned q;
    q = (per_ps == 0) ? 1 : (win_ps + per_ps - 1) / per_ps;
    return (q == 0) ? 1 : q;
  endfunction

  function automatic logic is_write(input logic sel, input logic wr);
    return sel & wr;
  endfunction

endpackage

// File: rtl/sram_sleep_sync.sv
`timescale 1ns/1ps
module sram_sleep_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[0] <= 1'b0;
          else        chain[0] <= d_i;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[g] <= 1'b0;
          else        chain[g] <= chain[g-1];
        end
      end
    end
  endgenerate

  assign q_o = chain[STAGES-1];
endmodule

// File: rtl/sram_sleep_fsm.sv
`timescale 1ns/1ps
module sram_sleep_fsm
  import sram_sleep_pkg::*;
#(
  parameter int unsigned ENTRY_CYC = 2,
  parameter int unsigned REC_CYC   = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_sync_i,
  output slp_state_e state_o,
  output logic       entry_hit_o,
  output logic       rec_done_o
);
  localparam int unsigned EW = (ENTRY_CYC < 2) ? 1 : $clog2(ENTRY_CYC);
  localparam int unsigned RW = (REC_CYC < 2) ? 1 : $clog2(REC_CYC);
  localparam logic [EW-1:0] ENT_LAST = EW'(ENTRY_CYC - 1);
  localparam logic [RW-1:0] REC_LAST = RW'(REC_CYC - 1);

  slp_state_e    state;
  logic [EW-1:0] ent_cnt;
  logic [RW-1:0] rec_cnt;

  assign entry_hit_o = req_sync_i && (state != ST_ASLEEP) && (ent_cnt == ENT_LAST);
  assign rec_done_o  = (state == ST_RECOVER) && (rec_cnt == REC_LAST);
  assign state_o     = state;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_AWAKE;
      ent_cnt <= '0;
      rec_cnt <= '0;
    end else if (state == ST_ASLEEP) begin
      ent_cnt <= '0;
      if (!req_sync_i) begin
        state   <= ST_RECOVER;
        rec_cnt <= '0;
      end
    end else if (entry_hit_o) begin
      state   <= ST_ASLEEP;
      ent_cnt <= '0;
    end else begin
      ent_cnt <= req_sync_i ? ent_cnt + 1'b1 : '0;
      if (rec_done_o)                state   <= ST_AWAKE;
      else if (state == ST_RECOVER)  rec_cnt <= rec_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/sram_sleep_gate.sv
`timescale 1ns/1ps
module sram_sleep_gate
  import sram_sleep_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  slp_state_e state_i,
  input  logic       sel_i,
  input  logic       wr_i,
  input  logic       oe_i,
  output logic       core_sel_o,
  output logic       core_wr_o,
  output logic       out_en_o,
  output logic       gate_o,
  output logic       blocked_o,
  output logic       err_o
);
  logic pass;

  always_comb begin
    blocked_o  = (state_i == ST_RECOVER) && is_write(sel_i, wr_i);
    pass       = (state_i == ST_AWAKE) || ((state_i == ST_RECOVER) && !blocked_o);
    gate_o     = pass;
    core_sel_o = sel_i & pass;
    core_wr_o  = is_write(sel_i, wr_i) & pass;
    out_en_o   = oe_i & (state_i != ST_ASLEEP);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         err_o <= 1'b0;
    else if (blocked_o) err_o <= 1'b1;
  end
endmodule

// File: rtl/sram_sleep_ctrl.sv
`timescale 1ns/1ps
module sram_sleep_ctrl
  import sram_sleep_pkg::*;
#(
  parameter int unsigned CLK_PERIOD_PS = 10000,
  parameter int unsigned RECOVERY_PS   = 20000,
  parameter int unsigned SYNC_STAGES   = 2,
  parameter int unsigned ENTRY_CYC     = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sleep_req_i,
  input  logic sel_i,
  input  logic wr_i,
  input  logic oe_i,
  output logic core_sel_o,
  output logic core_wr_o,
  output logic out_en_o,
  output logic gate_o,
  output logic sleep_o,
  output logic recov_o,
  output logic err_o
);
  localparam int unsigned REC_CYC = cycles_for(RECOVERY_PS, CLK_PERIOD_PS);

  // Named internal events, observed by the bound checker.
  logic       req_sync;
  logic       entry_hit;
  logic       rec_done;
  logic       blocked;
  slp_state_e state;

  sram_sleep_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (sleep_req_i),
    .q_o   (req_sync)
  );

  sram_sleep_fsm #(.ENTRY_CYC(ENTRY_CYC), .REC_CYC(REC_CYC)) u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_sync_i  (req_sync),
    .state_o     (state),
    .entry_hit_o (entry_hit),
    .rec_done_o  (rec_done)
  );

  sram_sleep_gate u_gate (
    .clk        (clk),
    .rst_n      (rst_n),
    .state_i    (state),
    .sel_i      (sel_i),
    .wr_i       (wr_i),
    .oe_i       (oe_i),
    .core_sel_o (core_sel_o),
    .core_wr_o  (core_wr_o),
    .out_en_o   (out_en_o),
    .gate_o     (gate_o),
    .blocked_o  (blocked),
    .err_o      (err_o)
  );

  assign sleep_o = (state == ST_ASLEEP);
  assign recov_o = (state == ST_RECOVER);
endmodule

// File: rtl/sram_sleep_ctrl_chk.sv
`timescale 1ns/1ps
module sram_sleep_ctrl_chk #(
  parameter int unsigned REC_CYC = 2
) (
  input logic clk,
  input logic rst_n,
  input logic sel_i,
  input logic core_sel_o,
  input logic core_wr_o,
  input logic out_en_o,
  input logic gate_o,
  input logic sleep_o,
  input logic recov_o,
  input logic err_o,
  input logic req_sync,
  input logic blocked
);
  logic [15:0] rec_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       rec_run <= '0;
    else if (recov_o) rec_run <= rec_run + 16'd1;
    else              rec_run <= '0;
  end

  assert_asleep_gated_R4: assert property (@(posedge clk) disable iff (!rst_n)
    sleep_o |-> (!gate_o && !core_sel_o && !core_wr_o && !out_en_o));

  assert_entry_needs_sync_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sleep_o) |-> ($past(req_sync) && $past(req_sync, 2)));

  assert_exit_to_recover_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sleep_o) |-> recov_o);

  assert_recover_bounded_R5: assert property (@(posedge clk) disable iff (!rst_n)
    recov_o |-> (rec_run < 16'(REC_CYC)));

  assert_no_write_in_recover_R7: assert property (@(posedge clk) disable iff (!rst_n)
    recov_o |-> !core_wr_o);

  assert_err_on_block_R8: assert property (@(posedge clk) disable iff (!rst_n)
    blocked |=> err_o);

  assert_err_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |=> err_o);

  assert_awake_pass_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!sleep_o && !recov_o) |-> (gate_o && (core_sel_o == sel_i)));
endmodule

bind sram_sleep_ctrl sram_sleep_ctrl_chk #(.REC_CYC(REC_CYC)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .sel_i      (sel_i),
  .core_sel_o (core_sel_o),
  .core_wr_o  (core_wr_o),
  .out_en_o   (out_en_o),
  .gate_o     (gate_o),
  .sleep_o    (sleep_o),
  .recov_o    (recov_o),
  .err_o      (err_o),
  .req_sync   (req_sync),
  .blocked    (blocked)
);

// File: tb/sram_sleep_ctrl_tb.sv
`timescale 1ns/1ps
module sram_sleep_ctrl_tb;
  localparam int unsigned PER_PS = 10000;
  localparam int unsigned WIN_PS = 45000;

  // Recovery length restated: smallest n with n*period >= window, at least 1.
  function automatic int unsigned exp_rec(input int unsigned w, input int unsigned p);
    int unsigned n;
    n = 1;
    while (n * p < w) n++;
    return n;
  endfunction
  localparam int unsigned REC = exp_rec(WIN_PS, PER_PS);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sleep_req_i = 1'b0, sel_i = 1'b0, wr_i = 1'b0, oe_i = 1'b0;
  logic core_sel_o, core_wr_o, out_en_o, gate_o, sleep_o, recov_o, err_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  // Bench model: synchroniser history, streak, mode (0 awake, 1 asleep, 2 recovering).
  logic m_q1, m_q2, m_err;
  int   m_streak, m_mode, m_rc;

  sram_sleep_ctrl #(.CLK_PERIOD_PS(PER_PS), .RECOVERY_PS(WIN_PS)) u_dut (
    .clk(clk), .rst_n(rst_n), .sleep_req_i(sleep_req_i), .sel_i(sel_i),
    .wr_i(wr_i), .oe_i(oe_i), .core_sel_o(core_sel_o), .core_wr_o(core_wr_o),
    .out_en_o(out_en_o), .gate_o(gate_o), .sleep_o(sleep_o),
    .recov_o(recov_o), .err_o(err_o)
  );

  always #5 clk = ~clk;

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    m_q1 = 0; m_q2 = 0; m_err = 0; m_streak = 0; m_mode = 0; m_rc = 0;
  endtask

  task automatic model_edge(input logic rq, input logic s, input logic w);
    logic n1, n2;
    n1 = rq; n2 = m_q1;
    if (m_mode == 2 && s && w) m_err = 1;
    if (m_mode == 1) begin
      m_streak = 0;
      if (!m_q2) begin m_mode = 2; m_rc = 0; end
    end else if (m_q2 && m_streak + 1 >= 2) begin
      m_mode = 1; m_streak = 0;
    end else begin
      m_streak = m_q2 ? m_streak + 1 : 0;
      if (m_mode == 2) begin
        m_rc++;
        if (m_rc == int'(REC)) m_mode = 0;
      end
    end
    m_q1 = n1; m_q2 = n2;
  endtask

  // One cycle: drive, compare combinational view, take the edge, return at negedge.
  task automatic cyc(input logic rq, input logic s, input logic w, input logic o);
    logic eg;
    logic [7:0] e, a;
    string tag;
    sleep_req_i = rq; sel_i = s; wr_i = w; oe_i = o;
    #1;
    eg = (m_mode == 0) || (m_mode == 2 && !(s && w));
    e = {1'b0, s & eg, s & w & eg, o & (m_mode != 1), eg, m_mode == 1, m_mode == 2, m_err};
    a = {1'b0, core_sel_o, core_wr_o, out_en_o, gate_o, sleep_o, recov_o, err_o};
    tag = (m_mode == 1) ? "R4" : (m_mode == 2) ? "R6 R7 R8" : "R9 R8";
    check(tag, a, e);
    @(posedge clk);
    model_edge(rq, s, w);
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 0;
    sleep_req_i = 0; sel_i = 0; wr_i = 0; oe_i = 0;
    repeat (3) @(negedge clk);
    model_reset();
    rst_n = 1;
    #1;
    check("R1", {4'b0, sleep_o, recov_o, err_o, gate_o}, 8'b0000_0001);
    @(negedge clk);
  endtask

  initial begin
    int first;
    void'($urandom(32'h5EED_1234));
    do_reset();

    // R9: pass-through while awake; a write does not set the flag.
    cyc(0, 1, 1, 1); cyc(0, 1, 0, 0); cyc(0, 0, 1, 1);

    // R2: latency from a held request.
    first = -1;
    for (int i = 1; i <= 8; i++) begin
      cyc(1, 1, 0, 1);
      if (sleep_o && first < 0) first = i;
    end
    check("R2", 8'(first), 8'd4);
    // R4: commands ignored while asleep.
    cyc(1, 1, 1, 1); cyc(1, 1, 0, 1);

    // R5: exit latency and window length.
    first = -1;
    for (int i = 1; i <= 4; i++) begin
      cyc(0, 0, 0, 1);
      if (!sleep_o && first < 0) first = i;
    end
    check("R5", 8'(first), 8'd3);
    // One recovery cycle already elapsed; count the remainder.
    first = 1;
    while (recov_o && first < 50) begin cyc(0, 1, 0, 1); first++; end
    check("R5", 8'(first), 8'(REC));
    check("R8", {7'b0, err_o}, 8'd0);

    // R3: one-edge pulse does not enter sleep.
    cyc(1, 0, 0, 0);
    first = 0;
    for (int i = 0; i < 8; i++) begin cyc(0, 0, 0, 0); if (sleep_o) first = 1; end
    check("R3", 8'(first), 8'd0);

    // R7/R8: write during recovery blocked, flag sticks.
    for (int i = 0; i < 6; i++) cyc(1, 0, 0, 0);
    for (int i = 0; i < 3; i++) cyc(0, 0, 0, 0);
    check("R5", {6'b0, sleep_o, recov_o}, 8'b01);
    cyc(0, 1, 1, 1);
    check("R8", {7'b0, err_o}, 8'd1);
    for (int i = 0; i < 10; i++) cyc(0, 1, 0, 1);
    check("R8", {7'b0, err_o}, 8'd1);

    // R10: re-request at the start of recovery.
    for (int i = 0; i < 6; i++) cyc(1, 0, 0, 0);
    for (int i = 0; i < 3; i++) cyc(0, 0, 0, 0);
    first = -1;
    for (int i = 1; i <= 6; i++) begin
      cyc(1, 1, 0, 0);
      if (sleep_o && first < 0) first = i;
    end
    check("R10", 8'(first), 8'd4);

    // R1: reset clears the flag.
    do_reset();

    // Random mix against the model.
    for (int blk = 0; blk < 400; blk++) begin
      logic rq;
      int len;
      rq  = 1'($urandom_range(0, 1));
      len = $urandom_range(1, 9);
      for (int i = 0; i < len; i++)
        cyc(rq, 1'($urandom), 1'($urandom), 1'($urandom));
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog R1 actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end
endmodule